// File: doc/BRIEF.md
# Odd-Weight-Column SEC-DED Codec

This block protects a data word with a single-error-correcting, double-error-detecting linear code. It has two independent paths. The encoding path takes a data word and produces a codeword that holds the data followed by R check bits. The decoding path takes a stored codeword, which may hold errors, and returns the data word with a single-bit error corrected. It also raises a flag when it has corrected an error and a separate flag when it has found an error it cannot correct.

The parity-check matrix is the identity on the check bits, side by side with a matrix Q that has one column per data bit. Every column of the full matrix has odd weight. Because of this, the parity of the syndrome weight tells odd error counts from even ones, and no extra overall parity bit is needed. K data bits can be protected by R check bits as long as K is at most 2^(R-1) − R. A parameter chooses between outputs registered by one clock and purely combinational outputs.

Top module: `secded_codec`

## Requirements
- R1: Codeword layout. Bits [K-1:0] of the codeword are the data bits, unchanged. Check bit i sits at codeword bit K+i and equals the XOR of every data bit j whose Q column has bit i set.
- R2: Q columns are assigned to data bits from bit 0 upward. They take every weight-3 R-bit value in increasing numeric order, then every weight-5 value in increasing order, and so on. With R=6: data bit 0 → 0x07, bit 1 → 0x0B, bit 2 → 0x0D, bit 3 → 0x0E, bit 4 → 0x13, bit 19 → 0x38, bit 20 → 0x1F, bit 25 → 0x3E.
- R3: An error-free codeword returns its data bits unchanged, and both flags read 0.
- R4: A single flipped data bit is restored in the output data. The corrected flag reads 1 and the uncorrectable flag reads 0.
- R5: A single flipped check bit leaves the output data equal to the original data. The corrected flag reads 1 and the uncorrectable flag reads 0.
- R6: Any two flipped bits give an even, nonzero syndrome. The uncorrectable flag reads 1, the corrected flag reads 0, and the output data equals the received data bits, unmodified. The two flags are never 1 together.
- R7: A syndrome of odd weight that matches no column of the matrix is treated as uncorrectable. This can happen only when K is below the maximum. The uncorrectable flag reads 1 and the received data bits pass through unmodified. Example: with R=6 and K=20, flipping check bits 0 to 4 gives syndrome 0x1F, which is unused.
- R8: With OUT_REG=1, all outputs change exactly one clock edge after their inputs. While reset is low, the codeword, data and both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | K | Data word to be encoded |
| enc_code_o | output | K+R | Codeword: data in the low bits, check bits in the high bits |
| dec_code_i | input | K+R | Received codeword to be decoded |
| dec_data_o | output | K | Data word after correction |
| dec_fixed_o | output | 1 | A single error was found and corrected |
| dec_fatal_o | output | 1 | An error was found that cannot be corrected |

## Verification
Encoding and decoding run in the same cycle on unrelated words. The bench feeds a fresh data word to the encoder every cycle while the decoder receives a different word with a chosen error pattern. Both outputs are compared every clock against a behavioural model, so that interference between the two paths would show up.

The second overlap is on the decode side: correction and the uncorrectable flag come from the same syndrome. Every single-bit position is swept, as are double errors across data, check bits and the boundary between them. A smaller instance receives a five-bit error whose syndrome falls outside its column set. In each case the bench judges that at most one flag rises and that the data is either repaired or passed through unmodified.

// File: rtl/secded_pkg.sv
package secded_pkg;

   localparam int MAX_R = 16;

   // Column idx of Q: odd weights from 3 upward, ascending value within a weight.
   function automatic logic [MAX_R-1:0] q_column(input int r, input int idx);
      int cnt;
      logic [MAX_R-1:0] res;
      cnt = 0;
      res = '0;
      for (int w = 3; w <= r; w += 2) begin
         for (int v = 0; v < (1 << r); v++) begin
            if ($countones(v) == w) begin
               if (cnt == idx) res = v[MAX_R-1:0];
               cnt++;
            end
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/secded_qmul.sv
module secded_qmul #(
   parameter int R = 6,
   parameter int K = 26
) (
   input  logic [K-1:0] d_i,
   output logic [R-1:0] p_o
);
   logic [R-1:0] term [K];

   for (genvar j = 0; j < K; j++) begin : g_col
      localparam logic [secded_pkg::MAX_R-1:0] CJ = secded_pkg::q_column(R, j);
      assign term[j] = d_i[j] ? CJ[R-1:0] : '0;
   end

   always_comb begin
      p_o = '0;
      for (int j = 0; j < K; j++) p_o = p_o ^ term[j];
   end
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector #(
   parameter int R = 6,
   parameter int K = 26
) (
   input  logic [R-1:0] syn_i,
   input  logic [K-1:0] raw_i,
   output logic [K-1:0] data_o,
   output logic         fixed_o,
   output logic         fatal_o
);
   localparam int N = K + R;

   logic [N-1:0] hit;

   for (genvar p = 0; p < N; p++) begin : g_pos
      if (p < K) begin : g_data
         localparam logic [secded_pkg::MAX_R-1:0] HC = secded_pkg::q_column(R, p);
         assign hit[p] = (syn_i == HC[R-1:0]);
      end else begin : g_chk
         localparam logic [R-1:0] HC = R'(1) << (p - K);
         assign hit[p] = (syn_i == HC);
      end
   end

   assign data_o  = raw_i ^ hit[K-1:0];
   assign fixed_o = |hit;
   assign fatal_o = (syn_i != '0) && !(|hit);
endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
   parameter int R       = 6,
   parameter int K       = 26,
   parameter bit OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [K-1:0]   enc_data_i,
   output logic [K+R-1:0] enc_code_o,
   input  logic [K+R-1:0] dec_code_i,
   output logic [K-1:0]   dec_data_o,
   output logic           dec_fixed_o,
   output logic           dec_fatal_o
);
   localparam int N    = K + R;
   localparam int KMAX = (1 << (R - 1)) - R;

   if (R < 3 || R > secded_pkg::MAX_R) begin : g_bad_r
      $error("secded_codec: R out of range");
   end
   if (K < 1 || K > KMAX) begin : g_bad_k
      $error("secded_codec: K exceeds 2^(R-1)-R");
   end

   logic [R-1:0] enc_chk, dec_qd, syn;
   logic [N-1:0] code_c;
   logic [K-1:0] data_c;
   logic         fixed_c, fatal_c;

   secded_qmul #(.R(R), .K(K)) u_enc (.d_i(enc_data_i), .p_o(enc_chk));
   assign code_c = {enc_chk, enc_data_i};

   secded_qmul #(.R(R), .K(K)) u_dec (.d_i(dec_code_i[K-1:0]), .p_o(dec_qd));
   assign syn = dec_qd ^ dec_code_i[N-1:K];

   secded_corrector #(.R(R), .K(K)) u_fix (
      .syn_i  (syn),
      .raw_i  (dec_code_i[K-1:0]),
      .data_o (data_c),
      .fixed_o(fixed_c),
      .fatal_o(fatal_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            enc_code_o  <= '0;
            dec_data_o  <= '0;
            dec_fixed_o <= 1'b0;
            dec_fatal_o <= 1'b0;
         end else begin
            enc_code_o  <= code_c;
            dec_data_o  <= data_c;
            dec_fixed_o <= fixed_c;
            dec_fatal_o <= fatal_c;
         end
      end

      // R7: uncorrectable word leaves the data as received
      p_fatal_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
         dec_fatal_o |-> dec_data_o == $past(dec_code_i[K-1:0]));
      // R4: a correction touches at most one data bit
      p_fix_onebit_r4: assert property (@(posedge clk) disable iff (!rst_n)
         dec_fixed_o |-> $countones(dec_data_o ^ $past(dec_code_i[K-1:0])) <= 1);
   end else begin : g_comb
      assign enc_code_o  = code_c;
      assign dec_data_o  = data_c;
      assign dec_fixed_o = fixed_c;
      assign dec_fatal_o = fatal_c;
   end

   // R6: flags mutually exclusive
   p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fixed_c && fatal_c));
   // R6: even nonzero syndrome is always uncorrectable
   p_even_syn_fatal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (syn != '0 && !(^syn)) |-> (fatal_c && !fixed_c));
   // R3: zero syndrome means clean pass-through
   p_zero_syn_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (syn == '0) |-> (!fixed_c && !fatal_c && data_c == dec_code_i[K-1:0]));
endmodule

// File: tb/tb_secded_codec.sv
`timescale 1ns/1ps
module tb_secded_codec;
   localparam int R  = 6;
   localparam int K  = 26;
   localparam int N  = K + R;
   localparam int K2 = 20;
   localparam int N2 = K2 + R;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [K-1:0]  enc_d = '0;
   logic [N-1:0]  enc_c;
   logic [N-1:0]  dec_c = '0;
   logic [K-1:0]  dec_d;
   logic          fx, ft;
   logic [K2-1:0] enc_d2 = '0;
   logic [N2-1:0] enc_c2;
   logic [N2-1:0] dec_c2 = '0;
   logic [K2-1:0] dec_d2;
   logic          fx2, ft2;

   secded_codec #(.R(R), .K(K), .OUT_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .enc_data_i(enc_d), .enc_code_o(enc_c),
      .dec_code_i(dec_c), .dec_data_o(dec_d), .dec_fixed_o(fx), .dec_fatal_o(ft));

   secded_codec #(.R(R), .K(K2), .OUT_REG(1'b1)) dut2 (
      .clk(clk), .rst_n(rst_n), .enc_data_i(enc_d2), .enc_code_o(enc_c2),
      .dec_code_i(dec_c2), .dec_data_o(dec_d2), .dec_fixed_o(fx2), .dec_fatal_o(ft2));

   int checks = 0;
   int fails  = 0;

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural model: columns ordered by weight, then value
   function automatic logic [63:0] mcol(input int r, input int idx);
      int n = 0;
      int w = 3;
      while (w <= r) begin
         for (int v = 1; v < (1 << r); v++) begin
            int pc = 0;
            for (int b = 0; b < r; b++) pc += (v >> b) & 1;
            if (pc == w) begin
               if (n == idx) return 64'(v);
               n++;
            end
         end
         w += 2;
      end
      return 64'd0;
   endfunction

   function automatic logic [63:0] menc(input int k, input int r, input logic [63:0] d);
      logic [63:0] c = '0;
      for (int j = 0; j < k; j++) if (d[j]) c ^= mcol(r, j);
      return (d & ((64'd1 << k) - 1)) | (c << k);
   endfunction

   // returns {fatal, fixed, data}
   function automatic logic [65:0] mdec(input int k, input int r, input logic [63:0] cw);
      logic [63:0] s = '0;
      logic [63:0] dat;
      int pos = -1;
      for (int p = 0; p < k + r; p++)
         if (cw[p]) s ^= (p < k) ? mcol(r, p) : (64'd1 << (p - k));
      for (int p = 0; p < k + r; p++)
         if (s != 0 && s == ((p < k) ? mcol(r, p) : (64'd1 << (p - k)))) pos = p;
      dat = cw & ((64'd1 << k) - 1);
      if (s == 0) return {2'b00, dat};
      if (pos < 0) return {2'b10, dat};
      if (pos < k) dat[pos] = ~dat[pos];
      return {2'b01, dat};
   endfunction

   logic [63:0] e_c, e_c2;
   logic [65:0] e_d, e_d2;
   string       p_tag;
   bit          pend = 0;

   task automatic compare_pending();
      if (pend) begin
         chk(64'(enc_c), e_c, {p_tag, " enc R1"});
         chk(64'(dec_d), e_d[63:0], {p_tag, " data"});
         chk(64'(fx), 64'(e_d[64]), {p_tag, " fixed"});
         chk(64'(ft), 64'(e_d[65]), {p_tag, " fatal"});
         chk(64'(fx && ft), 64'd0, {p_tag, " flags exclusive R6"});
         chk(64'(enc_c2), e_c2, {p_tag, " enc2 R1"});
         chk(64'(dec_d2), e_d2[63:0], {p_tag, " data2"});
         chk(64'(fx2), 64'(e_d2[64]), {p_tag, " fixed2"});
         chk(64'(ft2), 64'(e_d2[65]), {p_tag, " fatal2"});
      end
   endtask

   // one cycle: check previous vector, apply next
   task automatic apply(input logic [63:0] d, input logic [63:0] dd, input logic [63:0] flip,
                        input logic [63:0] d2, input logic [63:0] flip2, input string tag);
      logic [63:0] cw, cw2;
      @(negedge clk);
      compare_pending();
      cw  = menc(K, R, dd) ^ flip;
      cw2 = menc(K2, R, d2) ^ flip2;
      enc_d  = d[K-1:0];
      dec_c  = cw[N-1:0];
      enc_d2 = d2[K2-1:0];
      dec_c2 = cw2[N2-1:0];
      e_c  = menc(K, R, d);
      e_c2 = menc(K2, R, d2);
      e_d  = mdec(K, R, cw);
      e_d2 = mdec(K2, R, cw2);
      p_tag = tag;
      pend = 1;
   endtask

   initial begin : watchdog
      #200000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [63:0] a, b;
      // R8: reset state with live inputs
      enc_d = '1;
      dec_c = 32'h0000_0001;
      repeat (3) @(negedge clk);
      chk(64'(enc_c), 64'd0, "R8 reset code");
      chk(64'(dec_d), 64'd0, "R8 reset data");
      chk(64'({fx, ft}), 64'd0, "R8 reset flags");
      rst_n = 1'b1;

      // R2: column literals
      apply(64'd1 << 0, 0, 0, 0, 0, "R2");
      @(negedge clk); chk(64'(enc_c[N-1:K]), 64'h07, "R2 col0");
      pend = 0;
      apply(64'd1 << 1, 0, 0, 0, 0, "R2");
      @(negedge clk); chk(64'(enc_c[N-1:K]), 64'h0B, "R2 col1"); pend = 0;
      apply(64'd1 << 4, 0, 0, 0, 0, "R2");
      @(negedge clk); chk(64'(enc_c[N-1:K]), 64'h13, "R2 col4"); pend = 0;
      apply(64'd1 << 19, 0, 0, 0, 0, "R2");
      @(negedge clk); chk(64'(enc_c[N-1:K]), 64'h38, "R2 col19"); pend = 0;
      apply(64'd1 << 20, 0, 0, 0, 0, "R2");
      @(negedge clk); chk(64'(enc_c[N-1:K]), 64'h1F, "R2 col20"); pend = 0;
      apply(64'd1 << 25, 0, 0, 0, 0, "R2");
      @(negedge clk); chk(64'(enc_c[N-1:K]), 64'h3E, "R2 col25"); pend = 0;

      // R3 / R1: clean words, encoder and decoder on different words
      apply(64'h3FF_FFFF, 64'h155_5555, 0, 64'hA_BCDE, 0, "R3 clean");
      apply(64'h0, 64'h2AA_AAAA, 0, 64'hF_FFFF, 0, "R3 clean");
      apply(64'h123_4567, 64'h3FF_FFFF, 0, 64'h0, 0, "R3 clean");
      apply(64'h0DE_ADBE, 64'h0, 0, 64'h5_5555, 0, "R3 clean");

      // R4: every data bit flipped
      for (int p = 0; p < K; p++) begin
         a = 64'h2C3_5A1F ^ (64'(p) * 64'h1_1111);
         apply(a, a, 64'd1 << p, a, 64'd1 << (p % K2), "R4 single data");
      end
      // R5: every check bit flipped
      for (int p = K; p < N; p++)
         apply(64'h1F0_F0F0, 64'h0A5_5AA5, 64'd1 << p, 64'h3_C3C3, 64'd1 << (p - K + K2), "R5 single check");

      // R6: double errors across data, check and the boundary
      for (int i = 0; i < 12; i++) begin
         int p1 = (i * 7) % N;
         int p2 = (i * 7 + 3 + i) % N;
         if (p1 == p2) p2 = (p2 + 1) % N;
         b = (64'd1 << p1) | (64'd1 << p2);
         apply(64'h155_AA55, 64'h0F0_0F0F + 64'(i), b, 64'h1_2345, 64'h3 << (i % (N2 - 1)), "R6 double");
      end
      apply(0, 64'h3FF_FFFF, (64'd1 << (K - 1)) | (64'd1 << K), 0, 0, "R6 boundary");

      // R7: unmatched odd syndrome on the reduced-K instance
      apply(0, 64'h111_1111, 0, 64'h0_BEEF, 64'h1F << K2, "R7 unmatched");
      @(negedge clk);
      compare_pending();
      pend = 0;
      chk(64'(ft2), 64'd1, "R7 fatal2");
      chk(64'(dec_d2), 64'h0_BEEF, "R7 raw data2");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule